// File: doc/BRIEF.md
# Tiled Frame-Buffer Pixel Address Generator

This block turns a pixel coordinate into the byte address of the row that holds that pixel in a frame buffer laid out as 8x8 character tiles in RAM. The tiles are stored column by column. A tile takes 16, 32 or 64 bytes, depending on the colour depth, and each pixel row inside a tile takes two bytes of the bitplane pair at that row. The caller gives the screen base register, the colour mode, the two height-select bits and the object-drawing flag. From these the block derives the effective height, the total frame size, the frame base address, the column offset and the final tile-row address.

Three line counts (128, 160 and 192) use a plain stride: each column holds as many tiles as the screen has tile rows. The 256-line layout is different. It splits both the column index and the tile-row index into a high half and a low half of 16 each, and the two halves have different strides. The object-drawing flag forces this 256-line layout for addressing. The frame size still follows the height the select bits chose. If the frame would run past the end of RAM, the base is pulled down so that the frame ends exactly at the top of RAM.

The block has no internal state other than its output register. Every result appears one clock after its inputs are presented.

Top module: `pixel_addr_gen`

## Requirements
- R1: All five outputs are registered and reflect the inputs present at the previous rising clock edge. While `rst_n` is low, every output reads zero.
- R2: The line count is selected by the index {`hsel_hi`,`hsel_lo`}: 0→128, 1→160, 2→192, 3→256. With `obj_mode` low, `eff_height` reports that count.
- R3: With `obj_mode` high, `eff_height` is 256 and addressing uses the 256-line layout, whatever the select bits are.
- R4: `screen_size` uses the selected line count, not the effective one. It is 32768 when the index is 3. Otherwise it is lines×4×F, where F is 16 for mode 0, 32 for modes 1 and 2, and 64 for mode 3.
- R5: `frame_base` is `scr_base`×1024 when that base plus `screen_size` does not exceed the RAM size (RAM_BANKS×65536). Otherwise it is the RAM size minus `screen_size`.
- R6: For effective heights 128, 160 and 192, with column c = `pix_x`/8, `col_offset` = c×(lines/8)×B, where B is 16 for mode 0, 32 for mode 1 and 64 for modes 2 and 3.
- R7: For the 256-line layout, `col_offset` = ((c/16)×4096 + (c mod 16)×16)×B/16.
- R8: `tile_addr` = (frame_base + col_offset + T + (`pix_y` mod 8)×2) mod 2^ADDR_W, where ADDR_W = 16 + ceil(log2(RAM_BANKS)) and r = `pix_y`/8. T is r×B for the plain layout and ((r/16)×8192 + (r mod 16)×256)×B/16 for the 256-line layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_x | input | 8 | Pixel column |
| pix_y | input | 8 | Pixel row |
| scr_base | input | 8 | Screen base register, in units of 1 KB |
| color_mode | input | 2 | Colour depth: 0, 1, 2 or 3 |
| hsel_lo | input | 1 | Low bit of the height select index |
| hsel_hi | input | 1 | High bit of the height select index |
| obj_mode | input | 1 | Object-drawing flag, forces the 256-line layout |
| tile_addr | output | ADDR_W | Byte address of the pixel's tile row |
| col_offset | output | 17 | Offset of the pixel's tile column from the frame base |
| eff_height | output | 9 | Effective line count |
| screen_size | output | 17 | Frame size in bytes |
| frame_base | output | ADDR_W | Frame base address after clamping |

## Verification
Some properties hold on every cycle and are checked there: the frame always fits inside RAM, a clamped frame ends exactly at the top of RAM, an unclamped base equals the register times 1024, the object flag forces a 256-line height, the largest select index yields a 32 KB frame, and every tile address is even. The exact column and row strides of each height and mode pair, the split into two halves of 16 in the 256-line layout, and the one-clock latency are shown only by the bench sweeps. Those sweeps cover every colour mode, every height index, both object-flag settings and every screen base value, and the bench computes the expected addresses arithmetically.

// File: rtl/pxg_pkg.sv
package pxg_pkg;

  localparam int CALC_W  = 20;
  localparam int SIZE_W  = 17;
  localparam int LINE_W  = 9;
  localparam int COORD_W = 8;
  localparam int TIDX_W  = COORD_W - 3;

  typedef logic [CALC_W-1:0] calc_t;

  // log2 of the bytes held by one 8x8 tile
  function automatic logic [2:0] tile_log2(input logic [1:0] mode);
    logic [2:0] s;
    case (mode)
      2'd0:    s = 3'd4;
      2'd1:    s = 3'd5;
      default: s = 3'd6;
    endcase
    return s;
  endfunction

  function automatic logic [LINE_W-1:0] lines_of(input logic [1:0] sel);
    logic [LINE_W-1:0] n;
    case (sel)
      2'd0:    n = 9'd128;
      2'd1:    n = 9'd160;
      2'd2:    n = 9'd192;
      default: n = 9'd256;
    endcase
    return n;
  endfunction

  // frame size in bytes, taken from the selected (not forced) height
  function automatic logic [SIZE_W-1:0] frame_bytes(input logic [1:0] sel,
                                                    input logic [1:0] mode);
    calc_t per;
    calc_t t;
    case (mode)
      2'd0:    per = calc_t'(16);
      2'd3:    per = calc_t'(64);
      default: per = calc_t'(32);
    endcase
    if (sel == 2'd3) t = calc_t'(32768);
    else             t = (calc_t'(lines_of(sel)) << 2) * per;
    return t[SIZE_W-1:0];
  endfunction

  // offset of tile column c from the frame base
  function automatic calc_t column_term(input logic [TIDX_W-1:0] c,
                                        input logic [1:0] sel,
                                        input logic [1:0] mode);
    calc_t sh;
    calc_t v;
    sh = calc_t'(tile_log2(mode));
    if (sel == 2'd3)
      v = (calc_t'(c & 5'h10) << (sh + calc_t'(4))) + (calc_t'(c & 5'h0f) << sh);
    else
      v = (calc_t'(c) * calc_t'(lines_of(sel) >> 3)) << sh;
    return v;
  endfunction

  // offset of tile row r inside its column
  function automatic calc_t rowtile_term(input logic [TIDX_W-1:0] r,
                                         input logic [1:0] sel,
                                         input logic [1:0] mode);
    calc_t sh;
    calc_t v;
    sh = calc_t'(tile_log2(mode));
    if (sel == 2'd3)
      v = (calc_t'(r & 5'h10) << (sh + calc_t'(5))) +
          (calc_t'(r & 5'h0f) << (sh + calc_t'(4)));
    else
      v = calc_t'(r) << sh;
    return v;
  endfunction

endpackage

// File: rtl/pxg_geometry.sv
module pxg_geometry
  import pxg_pkg::*;
(
  input  logic              hsel_lo,
  input  logic              hsel_hi,
  input  logic              obj_mode,
  input  logic [1:0]        color_mode,
  output logic [1:0]        sel_idx,
  output logic [1:0]        eff_idx,
  output logic [LINE_W-1:0] eff_lines,
  output logic [SIZE_W-1:0] size_bytes
);

  assign sel_idx    = {hsel_hi, hsel_lo};
  assign eff_idx    = obj_mode ? 2'd3 : sel_idx;
  assign eff_lines  = lines_of(eff_idx);
  assign size_bytes = frame_bytes(sel_idx, color_mode);

endmodule

// File: rtl/pxg_base_clamp.sv
module pxg_base_clamp
  import pxg_pkg::*;
#(
  parameter int RAM_BANKS = 4
) (
  input  logic [7:0]        scr_base,
  input  logic [SIZE_W-1:0] size_bytes,
  output calc_t             base_addr,
  output logic              clamp_hit
);

  localparam calc_t RAM_BYTES = calc_t'(RAM_BANKS) << 16;

  calc_t base_raw;
  calc_t frame_end;

  assign base_raw  = calc_t'({scr_base, 10'b0});
  assign frame_end = base_raw + calc_t'(size_bytes);
  assign clamp_hit = frame_end > RAM_BYTES;
  assign base_addr = clamp_hit ? (RAM_BYTES - calc_t'(size_bytes)) : base_raw;

endmodule

// File: rtl/pxg_offset.sv
module pxg_offset
  import pxg_pkg::*;
(
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [1:0]         eff_idx,
  input  logic [1:0]         color_mode,
  output calc_t              col_off,
  output calc_t              row_off,
  output calc_t              fine_off
);

  logic [TIDX_W-1:0] tile_col;
  logic [TIDX_W-1:0] tile_row;

  assign tile_col = pix_x[COORD_W-1:3];
  assign tile_row = pix_y[COORD_W-1:3];

  assign col_off  = column_term(tile_col, eff_idx, color_mode);
  assign row_off  = rowtile_term(tile_row, eff_idx, color_mode);
  assign fine_off = calc_t'({pix_y[2:0], 1'b0});

endmodule

// File: rtl/pixel_addr_gen.sv
module pixel_addr_gen
  import pxg_pkg::*;
#(
  parameter  int RAM_BANKS = 4,
  localparam int ADDR_W    = 16 + $clog2(RAM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        pix_x,
  input  logic [7:0]        pix_y,
  input  logic [7:0]        scr_base,
  input  logic [1:0]        color_mode,
  input  logic              hsel_lo,
  input  logic              hsel_hi,
  input  logic              obj_mode,
  output logic [ADDR_W-1:0] tile_addr,
  output logic [16:0]       col_offset,
  output logic [8:0]        eff_height,
  output logic [16:0]       screen_size,
  output logic [ADDR_W-1:0] frame_base
);

  generate
    if (RAM_BANKS < 1 || RAM_BANKS > 4) begin : g_bank_range
      $error("pixel_addr_gen: RAM_BANKS must lie in 1..4");
    end
  endgenerate

  logic [1:0]        sel_idx;
  logic [1:0]        eff_idx;
  logic [LINE_W-1:0] eff_lines;
  logic [SIZE_W-1:0] size_bytes;
  calc_t             base_addr;
  logic              clamp_hit;
  calc_t             col_off;
  calc_t             row_off;
  calc_t             fine_off;
  calc_t             addr_sum;
  logic              unused_hi_bits;

  pxg_geometry u_geom (
    .hsel_lo    (hsel_lo),
    .hsel_hi    (hsel_hi),
    .obj_mode   (obj_mode),
    .color_mode (color_mode),
    .sel_idx    (sel_idx),
    .eff_idx    (eff_idx),
    .eff_lines  (eff_lines),
    .size_bytes (size_bytes)
  );

  pxg_base_clamp #(.RAM_BANKS(RAM_BANKS)) u_clamp (
    .scr_base   (scr_base),
    .size_bytes (size_bytes),
    .base_addr  (base_addr),
    .clamp_hit  (clamp_hit)
  );

  pxg_offset u_offs (
    .pix_x      (pix_x),
    .pix_y      (pix_y),
    .eff_idx    (eff_idx),
    .color_mode (color_mode),
    .col_off    (col_off),
    .row_off    (row_off),
    .fine_off   (fine_off)
  );

  assign addr_sum = base_addr + col_off + row_off + fine_off;

  assign unused_hi_bits = ^{sel_idx, addr_sum[CALC_W-1:ADDR_W],
                            base_addr[CALC_W-1:ADDR_W], col_off[CALC_W-1:SIZE_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tile_addr   <= '0;
      col_offset  <= '0;
      eff_height  <= '0;
      screen_size <= '0;
      frame_base  <= '0;
    end else begin
      tile_addr   <= addr_sum[ADDR_W-1:0];
      col_offset  <= col_off[SIZE_W-1:0];
      eff_height  <= eff_lines;
      screen_size <= size_bytes;
      frame_base  <= base_addr[ADDR_W-1:0];
    end
  end

endmodule

// File: rtl/pxg_checker.sv
module pxg_checker
  import pxg_pkg::*;
#(
  parameter  int RAM_BANKS = 4,
  localparam int ADDR_W    = 16 + $clog2(RAM_BANKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        scr_base,
  input logic              hsel_lo,
  input logic              hsel_hi,
  input logic              obj_mode,
  input logic              clamp_hit,
  input logic [ADDR_W-1:0] tile_addr,
  input logic [8:0]        eff_height,
  input logic [16:0]       screen_size,
  input logic [ADDR_W-1:0] frame_base
);

  localparam calc_t RAM_BYTES = calc_t'(RAM_BANKS) << 16;

  // set once the output register has captured real inputs
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R2
  legal_height_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (eff_height == 9'd128) || (eff_height == 9'd160) ||
    (eff_height == 9'd192) || (eff_height == 9'd256));

  // R3
  obj_height_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(obj_mode) |-> eff_height == 9'd256);

  // R4
  full_size_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    ($past(hsel_hi) && $past(hsel_lo)) |-> screen_size == 17'd32768);

  // R5
  fits_ram_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (calc_t'(frame_base) + calc_t'(screen_size)) <= RAM_BYTES);

  // R5
  clamp_top_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(clamp_hit) |-> (calc_t'(frame_base) + calc_t'(screen_size)) == RAM_BYTES);

  // R5
  base_keep_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(!clamp_hit) |-> calc_t'(frame_base) == calc_t'({$past(scr_base), 10'b0}));

  // R8
  even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    tile_addr[0] == 1'b0);

endmodule

bind pixel_addr_gen pxg_checker #(.RAM_BANKS(RAM_BANKS)) u_pxg_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scr_base    (scr_base),
  .hsel_lo     (hsel_lo),
  .hsel_hi     (hsel_hi),
  .obj_mode    (obj_mode),
  .clamp_hit   (clamp_hit),
  .tile_addr   (tile_addr),
  .eff_height  (eff_height),
  .screen_size (screen_size),
  .frame_base  (frame_base)
);

// File: tb/sim_pixel_addr_gen.sv
module sim_pixel_addr_gen;

  localparam int BANKS = 2;
  localparam int AW    = 17;
  localparam int RAM   = BANKS * 65536;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    pix_x = 8'd0;
  logic [7:0]    pix_y = 8'd0;
  logic [7:0]    scr_base = 8'd0;
  logic [1:0]    color_mode = 2'd0;
  logic          hsel_lo = 1'b0;
  logic          hsel_hi = 1'b0;
  logic          obj_mode = 1'b0;
  logic [AW-1:0] tile_addr;
  logic [16:0]   col_offset;
  logic [8:0]    eff_height;
  logic [16:0]   screen_size;
  logic [AW-1:0] frame_base;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  int e_addr, e_col, e_h, e_sz, e_base;
  string t_col, t_h;

  always #10ns clk = ~clk;

  pixel_addr_gen #(.RAM_BANKS(BANKS)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .scr_base(scr_base), .color_mode(color_mode), .hsel_lo(hsel_lo),
    .hsel_hi(hsel_hi), .obj_mode(obj_mode), .tile_addr(tile_addr),
    .col_offset(col_offset), .eff_height(eff_height),
    .screen_size(screen_size), .frame_base(frame_base)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int line_count(input int s);
    return (s == 0) ? 128 : (s == 1) ? 160 : (s == 2) ? 192 : 256;
  endfunction

  // expected outputs, computed from the requirements
  task automatic model(input int x, input int y, input int b, input int m,
                       input int lo, input int hi, input int ob);
    int sel, esel, bpt, fac, c, r, row;
    sel  = hi * 2 + lo;
    esel = (ob != 0) ? 3 : sel;
    bpt  = (m == 0) ? 16 : (m == 1) ? 32 : 64;
    fac  = (m == 0) ? 16 : (m == 3) ? 64 : 32;
    e_sz = (sel == 3) ? 32768 : line_count(sel) * 4 * fac;
    e_base = b * 1024;
    if (e_base + e_sz > RAM) e_base = RAM - e_sz;
    c = x / 8;
    r = y / 8;
    if (esel == 3) begin
      e_col = ((c / 16) * 4096 + (c % 16) * 16) * (bpt / 16);
      row   = ((r / 16) * 8192 + (r % 16) * 256) * (bpt / 16);
      t_col = "R7";
    end else begin
      e_col = c * (line_count(esel) / 8) * bpt;
      row   = r * bpt;
      t_col = "R6";
    end
    e_h    = line_count(esel);
    t_h    = (ob != 0) ? "R3" : "R2";
    e_addr = (e_base + e_col + row + (y % 8) * 2) % (1 << AW);
  endtask

  task automatic apply(input int x, input int y, input int b, input int m,
                       input int lo, input int hi, input int ob);
    pix_x = 8'(x); pix_y = 8'(y); scr_base = 8'(b); color_mode = 2'(m);
    hsel_lo = lo[0]; hsel_hi = hi[0]; obj_mode = ob[0];
  endtask

  task automatic compare_all();
    chk("R8 tile_addr", int'(tile_addr), e_addr);
    chk({t_col, " col_offset"}, int'(col_offset), e_col);
    chk({t_h, " eff_height"}, int'(eff_height), e_h);
    chk("R4 screen_size", int'(screen_size), e_sz);
    chk("R5 frame_base", int'(frame_base), e_base);
  endtask

  task automatic run_vec(input int x, input int y, input int b, input int m,
                         input int lo, input int hi, input int ob);
    @(negedge clk);
    apply(x, y, b, m, lo, hi, ob);
    model(x, y, b, m, lo, hi, ob);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    apply(200, 77, 99, 3, 1, 0, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 reset tile_addr", int'(tile_addr), 0);
    chk("R1 reset col_offset", int'(col_offset), 0);
    chk("R1 reset eff_height", int'(eff_height), 0);
    chk("R1 reset screen_size", int'(screen_size), 0);
    chk("R1 reset frame_base", int'(frame_base), 0);
    rst_n = 1'b1;

    // R1: one-cycle latency, outputs hold until the next edge
    run_vec(13, 42, 5, 1, 0, 1, 0);
    apply(250, 250, 200, 3, 1, 1, 1);
    #2ns;
    chk("R1 hold tile_addr", int'(tile_addr), e_addr);
    chk("R1 hold eff_height", int'(eff_height), e_h);
    model(250, 250, 200, 3, 1, 1, 1);
    @(negedge clk);
    compare_all();

    // main sweep: every mode, height index and object setting
    for (int cfg = 0; cfg < 32; cfg++) begin
      for (int c = 0; c < 32; c++) begin
        for (int yi = 0; yi < 64; yi++) begin
          run_vec(c * 8 + ((c * 3 + yi) % 8), yi * 4 + (yi % 4),
                  (cfg * 53 + 17) % 256, cfg % 4, (cfg / 4) % 2,
                  (cfg / 8) % 2, cfg / 16);
        end
      end
    end

    // R5: every base value against every mode and height, clamp boundary
    for (int b = 0; b < 256; b++) begin
      for (int k = 0; k < 16; k++) begin
        run_vec(255, 255, b, k % 4, k / 4 % 2, k / 8, 0);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule